// File: doc/BRIEF.md
# Typed-Field Control and Status Register File

This block is a memory-mapped register file on a simple configuration bus with a valid strobe, separate write and read qualifiers, a 16-bit address and 32-bit data. It holds four registers at parameterised addresses. Each register is a set of fields, and each field has exactly one access behaviour: read-only, read-write, sticky cleared by a read, sticky cleared by a write, one-cycle pulse on an input's rising edge, event counter, or interrupt with separate set and clear inputs.

Core logic reads the configuration outputs and drives the status, event and interrupt inputs. Software reaches every field through the bus. Every bus access with a read or write qualifier gets a registered acknowledge one cycle later. An access to an address outside the map raises a registered error flag at the same time. Read data is registered and changes only on read cycles.

The default map is as follows. CTRL is at 0x0000 and holds the mode field in bits 7:0 (read-write) and the pulse output in bit 8. STAT is at 0x0004 and holds the level inputs in bits 3:0 (read-only), the read-cleared sticky bits in bits 7:4 and the write-cleared sticky bits in bits 11:8. COUNT is at 0x0008 and holds a 16-bit counter in bits 15:0. IRQ is at 0x000C and holds four interrupt bits in bits 3:0. All bits above a register's fields read as zero.

Top module: `cfgrf_regfile`

## Requirements
- R1: While reset is asserted (asynchronous, active low), and after it is released, the state is as follows: mode_q = 0x5A, and go_pulse, st_rc_q, st_wc_q, evt_count, irq_q, bus_ack, bus_err and bus_rdata are all zero.
- R2: bus_ack is high in the cycle after any cycle with bus_vld high together with bus_wr or bus_rd. It is low after any other cycle.
- R3: bus_err is high in the cycle after a cycle in which bus_vld is high and bus_addr matches none of the four register addresses. It is low after a valid cycle that hits a register.
- R4: bus_rdata loads only in cycles where bus_vld and bus_rd are both high. A mapped address returns that register's fields at the bit positions of the map, with zero in every other bit. An unmapped address returns zero. In all other cycles bus_rdata holds its value.
- R5: mode_q (CTRL bits 7:0) loads bus_wdata[7:0] on a write to CTRL. Any other cycle, including a write to another address, leaves it unchanged.
- R6: Each irq_q bit becomes (old AND NOT irq_clr) OR irq_set every cycle. When set and clear are both high on a bit, set wins.
- R7: st_rc_q (STAT bits 7:4) ORs in st_rc_in every cycle. A read of STAT returns the old sticky value and replaces the field with the st_rc_in value present in that same cycle.
- R8: st_wc_q (STAT bits 11:8) ORs in st_wc_in every cycle. A write to STAT makes it (old AND bus_wdata[11:8]) OR st_wc_in. Writing 0 therefore clears a bit unless its input is high in that cycle. A read does not change it.
- R9: A write to COUNT with bus_wdata[15:0] equal to zero clears evt_count, and this takes priority over a same-cycle increment. A write with a non-zero slice has no effect.
- R10: evt_count increments by one in each cycle that evt_inc is high. It wraps from 0xFFFF to 0.
- R11: go_pulse (CTRL bit 8) is high for exactly one cycle, starting one cycle after go_trig rises. It stays low while go_trig remains high.
- R12: STAT bits 3:0 return st_level as it is in the read cycle, with no storage in between. Reserved bits return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_vld | input | 1 | Access valid strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_ack | output | 1 | Registered acknowledge |
| bus_err | output | 1 | Registered unmapped-address flag |
| mode_q | output | 8 | Read-write mode field |
| go_trig | input | 1 | Trigger for the pulse field |
| go_pulse | output | 1 | One-cycle pulse on trigger rise |
| st_level | input | 4 | Live status, read-only |
| st_rc_in | input | 4 | Status events for the read-cleared sticky bits |
| st_rc_q | output | 4 | Read-cleared sticky bits |
| st_wc_in | input | 4 | Status events for the write-cleared sticky bits |
| st_wc_q | output | 4 | Write-cleared sticky bits |
| evt_inc | input | 1 | Counter increment |
| evt_count | output | 16 | Event counter |
| irq_set | input | 4 | Interrupt set |
| irq_clr | input | 4 | Interrupt clear |
| irq_q | output | 4 | Interrupt bits |

## Verification
Several pairs of this block's functions can act in the same cycle. A bus access to a sticky or counter field can coincide with that field's hardware input, and an interrupt set can coincide with its clear. The bench provokes each pair by driving the core-side input on the same clock edge as the bus access or as the opposing input. For a read of the read-cleared bits, the bench expects the returned data to show the old sticky value while the field takes on the new input. For a clearing write to the write-cleared bits, it expects a bit whose input is high to survive. For a zero write to the counter during an increment, it expects zero. For an interrupt bit that is both set and cleared, it expects the bit to end up set.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;

  typedef enum logic [2:0] {
    FK_RO, FK_RW, FK_RC, FK_WC, FK_PULSE, FK_CNT, FK_IRQ
  } fkind_e;

  function automatic logic [31:0] f_irq_next(input logic [31:0] old_v,
                                             input logic [31:0] set_v,
                                             input logic [31:0] clr_v);
    return (old_v & ~clr_v) | set_v;
  endfunction

  function automatic logic [31:0] f_wc_next(input logic [31:0] old_v,
                                            input logic [31:0] keep_v,
                                            input logic [31:0] ev_v);
    return (old_v & keep_v) | ev_v;
  endfunction

  function automatic logic [31:0] f_edge(input logic [31:0] now_v,
                                         input logic [31:0] prev_v);
    return now_v & ~prev_v;
  endfunction

endpackage

// File: rtl/cfgrf_decode.sv
module cfgrf_decode #(
  parameter int AW = 16,
  parameter int NREG = 4,
  parameter logic [NREG*AW-1:0] ADDR_TABLE = '0
) (
  input  logic [AW-1:0]   addr,
  output logic [NREG-1:0] hit,
  output logic            any_hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_cmp
    assign hit[i] = (addr == ADDR_TABLE[i*AW +: AW]);
  end
  assign any_hit = |hit;
endmodule

// File: rtl/cfgrf_field.sv
module cfgrf_field
  import cfgrf_pkg::*;
#(
  parameter int W = 1,
  parameter fkind_e KIND = FK_RW,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic         rd_hit,
  input  logic [W-1:0] wd,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic [W-1:0] q
);
  logic unused_sink;
  assign unused_sink = ^{wr_hit, rd_hit, wd, in_a, in_b};

  if (KIND == FK_RO) begin : g_ro
    assign q = in_a;
  end else if (KIND == FK_RW) begin : g_rw
    logic [W-1:0] st;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) st <= RST;
      else if (wr_hit) st <= wd;
    assign q = st;
    AST_RW_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_hit |=> $stable(st)); // R5
  end else if (KIND == FK_RC) begin : g_rc
    logic [W-1:0] st;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) st <= RST;
      else if (rd_hit) st <= in_a;
      else st <= st | in_a;
    assign q = st;
    AST_RC_REPLACE: assert property (@(posedge clk) disable iff (!rst_n) rd_hit |=> (st == $past(in_a))); // R7
  end else if (KIND == FK_WC) begin : g_wc
    logic [W-1:0] st;
    logic [W-1:0] keep;
    assign keep = wr_hit ? wd : '1;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) st <= RST;
      else st <= W'(f_wc_next(32'(st), 32'(keep), 32'(in_a)));
    assign q = st;
    AST_WC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (wr_hit && wd == '0 && in_a == '0) |=> (st == '0)); // R8
  end else if (KIND == FK_PULSE) begin : g_pulse
    logic [W-1:0] trig_d;
    logic [W-1:0] st;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        trig_d <= '0;
        st     <= RST;
      end else begin
        trig_d <= in_a;
        st     <= W'(f_edge(32'(in_a), 32'(trig_d)));
      end
    assign q = st;
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (|st) |=> ((st & $past(st)) == '0)); // R11
  end else if (KIND == FK_CNT) begin : g_cnt
    logic [W-1:0] st;
    logic         clr_evt;
    logic         inc_evt;
    assign clr_evt = wr_hit && (wd == '0);
    assign inc_evt = in_a[0];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) st <= RST;
      else if (clr_evt) st <= '0;
      else if (inc_evt) st <= st + 1'b1;
    assign q = st;
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) clr_evt |=> (st == '0)); // R9
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!clr_evt && !inc_evt) |=> $stable(st)); // R10
  end else begin : g_irq
    logic [W-1:0] st;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) st <= RST;
      else st <= W'(f_irq_next(32'(st), 32'(in_a), 32'(in_b)));
    assign q = st;
    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (|in_a) |=> ((st & $past(in_a)) == $past(in_a))); // R6
  end
endmodule

// File: rtl/cfgrf_regfile.sv
module cfgrf_regfile
  import cfgrf_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter logic [AW-1:0] A_CTRL  = 16'h0000,
  parameter logic [AW-1:0] A_STAT  = 16'h0004,
  parameter logic [AW-1:0] A_COUNT = 16'h0008,
  parameter logic [AW-1:0] A_IRQ   = 16'h000C,
  parameter int MODE_W = 8,
  parameter logic [MODE_W-1:0] MODE_RST = 8'h5A,
  parameter int ST_W = 4,
  parameter int CNT_W = 16,
  parameter int IRQ_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_vld,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_ack,
  output logic              bus_err,
  output logic [MODE_W-1:0] mode_q,
  input  logic              go_trig,
  output logic              go_pulse,
  input  logic [ST_W-1:0]   st_level,
  input  logic [ST_W-1:0]   st_rc_in,
  output logic [ST_W-1:0]   st_rc_q,
  input  logic [ST_W-1:0]   st_wc_in,
  output logic [ST_W-1:0]   st_wc_q,
  input  logic              evt_inc,
  output logic [CNT_W-1:0]  evt_count,
  input  logic [IRQ_W-1:0]  irq_set,
  input  logic [IRQ_W-1:0]  irq_clr,
  output logic [IRQ_W-1:0]  irq_q
);
  localparam int NREG = 4;
  localparam int IX_CTRL = 0, IX_STAT = 1, IX_COUNT = 2, IX_IRQ = 3;
  localparam int RC_LO = ST_W, WC_LO = 2 * ST_W;
  localparam logic [NREG*AW-1:0] TABLE = {A_IRQ, A_COUNT, A_STAT, A_CTRL};

  logic [NREG-1:0] hit, wr_hit, rd_hit;
  logic            any_hit;
  logic            acc_evt, rd_evt;
  logic [ST_W-1:0] lvl_q;
  logic [DW-1:0]   word [NREG];
  logic [DW-1:0]   rd_mux;

  cfgrf_decode #(.AW(AW), .NREG(NREG), .ADDR_TABLE(TABLE)) u_dec (
    .addr(bus_addr), .hit(hit), .any_hit(any_hit));

  assign acc_evt = bus_vld && (bus_wr || bus_rd);
  assign rd_evt  = bus_vld && bus_rd;
  assign wr_hit  = {NREG{bus_vld && bus_wr}} & hit;
  assign rd_hit  = {NREG{rd_evt}} & hit;

  cfgrf_field #(.W(MODE_W), .KIND(FK_RW), .RST(MODE_RST)) u_mode (
    .clk, .rst_n, .wr_hit(wr_hit[IX_CTRL]), .rd_hit(rd_hit[IX_CTRL]),
    .wd(bus_wdata[MODE_W-1:0]), .in_a('0), .in_b('0), .q(mode_q));

  cfgrf_field #(.W(1), .KIND(FK_PULSE), .RST(1'b0)) u_go (
    .clk, .rst_n, .wr_hit(wr_hit[IX_CTRL]), .rd_hit(rd_hit[IX_CTRL]),
    .wd(bus_wdata[MODE_W]), .in_a(go_trig), .in_b(1'b0), .q(go_pulse));

  cfgrf_field #(.W(ST_W), .KIND(FK_RO), .RST('0)) u_lvl (
    .clk, .rst_n, .wr_hit(wr_hit[IX_STAT]), .rd_hit(rd_hit[IX_STAT]),
    .wd(bus_wdata[ST_W-1:0]), .in_a(st_level), .in_b('0), .q(lvl_q));

  cfgrf_field #(.W(ST_W), .KIND(FK_RC), .RST('0)) u_rc (
    .clk, .rst_n, .wr_hit(wr_hit[IX_STAT]), .rd_hit(rd_hit[IX_STAT]),
    .wd(bus_wdata[RC_LO +: ST_W]), .in_a(st_rc_in), .in_b('0), .q(st_rc_q));

  cfgrf_field #(.W(ST_W), .KIND(FK_WC), .RST('0)) u_wc (
    .clk, .rst_n, .wr_hit(wr_hit[IX_STAT]), .rd_hit(rd_hit[IX_STAT]),
    .wd(bus_wdata[WC_LO +: ST_W]), .in_a(st_wc_in), .in_b('0), .q(st_wc_q));

  cfgrf_field #(.W(CNT_W), .KIND(FK_CNT), .RST('0)) u_cnt (
    .clk, .rst_n, .wr_hit(wr_hit[IX_COUNT]), .rd_hit(rd_hit[IX_COUNT]),
    .wd(bus_wdata[CNT_W-1:0]), .in_a({{(CNT_W-1){1'b0}}, evt_inc}), .in_b('0), .q(evt_count));

  cfgrf_field #(.W(IRQ_W), .KIND(FK_IRQ), .RST('0)) u_irq (
    .clk, .rst_n, .wr_hit(wr_hit[IX_IRQ]), .rd_hit(rd_hit[IX_IRQ]),
    .wd(bus_wdata[IRQ_W-1:0]), .in_a(irq_set), .in_b(irq_clr), .q(irq_q));

  always_comb begin
    for (int i = 0; i < NREG; i++) word[i] = '0;
    word[IX_CTRL][MODE_W-1:0]     = mode_q;
    word[IX_CTRL][MODE_W]         = go_pulse;
    word[IX_STAT][ST_W-1:0]       = lvl_q;
    word[IX_STAT][RC_LO +: ST_W]  = st_rc_q;
    word[IX_STAT][WC_LO +: ST_W]  = st_wc_q;
    word[IX_COUNT][CNT_W-1:0]     = evt_count;
    word[IX_IRQ][IRQ_W-1:0]       = irq_q;
    rd_mux = '0;
    for (int i = 0; i < NREG; i++) if (hit[i]) rd_mux = rd_mux | word[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= acc_evt;
      bus_err <= bus_vld && !any_hit;
      if (rd_evt) bus_rdata <= rd_mux;
    end

  AST_ACK_SET: assert property (@(posedge clk) disable iff (!rst_n) acc_evt |=> bus_ack); // R2
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !acc_evt |=> !bus_ack); // R2
  AST_ERR_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n) (bus_vld && !any_hit) |=> bus_err); // R3
  AST_ERR_MAPPED: assert property (@(posedge clk) disable iff (!rst_n) (bus_vld && any_hit) |=> !bus_err); // R3
  AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) bus_vld |-> $onehot0(hit)); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rd_evt |=> $stable(bus_rdata)); // R4
endmodule

// File: tb/cfgrf_regfile_test.sv
module cfgrf_regfile_test;
  localparam int CLK_P = 10;
  localparam logic [15:0] A_CTRL = 16'h0000, A_STAT = 16'h0004, A_COUNT = 16'h0008, A_IRQ = 16'h000C;

  logic clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  logic rst_n, bus_vld, bus_wr, bus_rd, bus_ack, bus_err;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0] mode_q;
  logic go_trig, go_pulse, evt_inc;
  logic [3:0] st_level, st_rc_in, st_rc_q, st_wc_in, st_wc_q, irq_set, irq_clr, irq_q;
  logic [15:0] evt_count;

  cfgrf_regfile uut (
    .clk, .rst_n, .bus_vld, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
    .bus_ack, .bus_err, .mode_q, .go_trig, .go_pulse, .st_level, .st_rc_in, .st_rc_q,
    .st_wc_in, .st_wc_q, .evt_inc, .evt_count, .irq_set, .irq_clr, .irq_q);

  int n_chk = 0, n_bad = 0;
  logic [31:0] rd_val;
  logic ack_s, err_s;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic r, input logic [15:0] a, input logic [31:0] d);
    bus_vld = 1'b1; bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    rd_val = bus_rdata; ack_s = bus_ack; err_s = bus_err;
    bus_vld = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 mode", 32'(mode_q), 32'h5A);
    chk("R1 zeros", {go_pulse, st_rc_q, st_wc_q, evt_count, irq_q, bus_ack, bus_err}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
  endtask

  task automatic t_rw;
    bus(1'b1, 1'b0, A_CTRL, 32'hFFFF_FEC3);
    chk("R2 ack write", 32'(ack_s), 32'h1);
    chk("R3 no err mapped", 32'(err_s), 32'h0);
    chk("R5 mode load", 32'(mode_q), 32'hC3);
    bus(1'b0, 1'b1, A_CTRL, 32'h0);
    chk("R4 read ctrl", rd_val, 32'h0000_00C3);
    bus(1'b1, 1'b0, A_STAT, 32'h0);
    chk("R5 other addr", 32'(mode_q), 32'hC3);
    chk("R4 rdata holds", bus_rdata, 32'h0000_00C3);
  endtask

  task automatic t_err;
    bus(1'b1, 1'b0, 16'h0010, 32'h1234);
    chk("R3 err write", {ack_s, err_s}, 32'h3);
    bus(1'b0, 1'b1, 16'h0002, 32'h0);
    chk("R3 err read", {ack_s, err_s}, 32'h3);
    chk("R4 unmapped zero", rd_val, 32'h0);
    bus(1'b0, 1'b0, A_CTRL, 32'h0);
    chk("R2 no qualifier", {ack_s, err_s}, 32'h0);
    bus(1'b0, 1'b0, 16'h0020, 32'h0);
    chk("R3 vld only unmapped", {ack_s, err_s}, 32'h1);
  endtask

  task automatic t_ro;
    st_level = 4'h9;
    bus(1'b0, 1'b1, A_STAT, 32'h0);
    chk("R12 level and reserved", rd_val, 32'h0000_0009);
    st_level = 4'h6;
    bus(1'b0, 1'b1, A_STAT, 32'h0);
    chk("R12 live level", rd_val, 32'h0000_0006);
    st_level = 4'h0;
  endtask

  task automatic t_rc;
    st_rc_in = 4'b0010;
    @(negedge clk);
    st_rc_in = 4'b0000;
    @(negedge clk);
    chk("R7 sticky", 32'(st_rc_q), 32'h2);
    st_rc_in = 4'b1000;
    bus(1'b0, 1'b1, A_STAT, 32'h0);
    st_rc_in = 4'b0000;
    chk("R7 read old", rd_val, 32'h0000_0020);
    chk("R7 replaced by input", 32'(st_rc_q), 32'h8);
    bus(1'b0, 1'b1, A_STAT, 32'h0);
    chk("R7 second read", rd_val, 32'h0000_0080);
    chk("R7 cleared", 32'(st_rc_q), 32'h0);
  endtask

  task automatic t_wc;
    st_wc_in = 4'b0110;
    @(negedge clk);
    st_wc_in = 4'b0000;
    chk("R8 sticky", 32'(st_wc_q), 32'h6);
    bus(1'b1, 1'b0, A_STAT, 32'h0000_0400);
    chk("R8 partial clear", 32'(st_wc_q), 32'h4);
    st_wc_in = 4'b0001;
    bus(1'b1, 1'b0, A_STAT, 32'h0);
    st_wc_in = 4'b0000;
    chk("R8 input beats clear", 32'(st_wc_q), 32'h1);
    bus(1'b0, 1'b1, A_STAT, 32'h0);
    chk("R8 read value", rd_val, 32'h0000_0100);
    chk("R8 read keeps", 32'(st_wc_q), 32'h1);
  endtask

  task automatic t_cnt;
    evt_inc = 1'b1;
    repeat (5) @(negedge clk);
    evt_inc = 1'b0;
    chk("R10 count five", 32'(evt_count), 32'h5);
    bus(1'b1, 1'b0, A_COUNT, 32'h1);
    chk("R9 nonzero ignored", 32'(evt_count), 32'h5);
    bus(1'b0, 1'b1, A_COUNT, 32'h0);
    chk("R4 read count", rd_val, 32'h5);
    evt_inc = 1'b1;
    bus(1'b1, 1'b0, A_COUNT, 32'h0);
    evt_inc = 1'b0;
    chk("R9 clear beats inc", 32'(evt_count), 32'h0);
    evt_inc = 1'b1;
    repeat (65535) @(negedge clk);
    chk("R10 full", 32'(evt_count), 32'hFFFF);
    @(negedge clk);
    evt_inc = 1'b0;
    chk("R10 wrap", 32'(evt_count), 32'h0);
  endtask

  task automatic t_irq;
    irq_set = 4'b0011;
    @(negedge clk);
    irq_set = 4'b0000;
    chk("R6 set", 32'(irq_q), 32'h3);
    irq_clr = 4'b0001;
    @(negedge clk);
    irq_clr = 4'b0000;
    chk("R6 clear", 32'(irq_q), 32'h2);
    irq_set = 4'b0100; irq_clr = 4'b0100;
    @(negedge clk);
    irq_set = 4'b0000; irq_clr = 4'b0000;
    chk("R6 set wins", 32'(irq_q), 32'h6);
    bus(1'b0, 1'b1, A_IRQ, 32'h0);
    chk("R4 read irq", rd_val, 32'h6);
    irq_clr = 4'b1111;
    @(negedge clk);
    irq_clr = 4'b0000;
    chk("R6 clear all", 32'(irq_q), 32'h0);
  endtask

  task automatic t_pulse;
    int highs = 0;
    go_trig = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (go_pulse) highs++;
    end
    chk("R11 one pulse", 32'(highs), 32'h1);
    go_trig = 1'b0;
    repeat (2) @(negedge clk);
    go_trig = 1'b1;
    @(negedge clk);
    chk("R11 pulse again", 32'(go_pulse), 32'h1);
    @(negedge clk);
    go_trig = 1'b0;
    chk("R11 pulse ends", 32'(go_pulse), 32'h0);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_vld = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; go_trig = 1'b0; evt_inc = 1'b0;
    st_level = '0; st_rc_in = '0; st_wc_in = '0; irq_set = '0; irq_clr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_err();
    t_ro();
    t_rc();
    t_wc();
    t_cnt();
    t_irq();
    t_pulse();
    summary();
    $finish;
  end
endmodule